// File: doc/BRIEF.md
# Gated Crosspoint Routing Switch Box

A purely combinational routing switch box sitting where four routing buses meet, one at each edge (north, south, east, west). Each edge carries an input bus and an output bus of the same width. A value travelling from one edge to another passes three configurable points in turn: an entry gate on its source edge line, a directional crosspoint on the switch matrix, and an exit gate on its destination edge line. All gates and crosspoints are set by a static configuration vector that is held constant while the fabric runs.

A line only joins lines of the same track index on other edges. A gate that is off presents logic 0, so an unconfigured box drives zeros everywhere. When several enabled crosspoints feed one output line their values are OR-merged, so no line is ever driven from two places. The edge gate bit of a line serves both directions: it admits the line's input into the matrix and releases the matrix result onto the line's output.

Top module: `sb_gated_switch`

## Requirements
- R1: Edge indices are north=0, south=1, east=2, west=3. With track width W=4 and a 128-bit configuration, the gate bit of edge e, track b sits at position 112 + 4*e + (3 - b); south track 0 is bit 119 and west track 0 is bit 127.
- R2: The crosspoint from source edge s to destination edge d (s != d) on track b sits at position 111 - (12*b + 3*((s+3) mod 4) + r), where m = ((s - d) mod 4 + 2) mod 4 and r = m, except r = 2 when m = 3. South track 0 to west track 0 is bit 111.
- R3: With the source gate, destination gate and crosspoint of a route all set, the destination output follows the source input.
- R4: With the source gate cleared, the route drives 0 whatever the input.
- R5: With the destination gate cleared, that output line is 0 whatever the matrix carries.
- R6: With the crosspoint cleared, the route drives 0 whatever the input.
- R7: An output fed by several complete routes is the OR of their source inputs.
- R8: Routes join only equal track indices; inputs on other tracks have no effect on a routed output.
- R9: Configuration bits 0 to 63 have no effect on any output.
- R10: An all-zero configuration drives 0 on every output for any input.
- R11: One source line may feed several destination edges at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_i | input | 128 | Static gate and crosspoint configuration |
| north_i | input | 4 | North edge input bus |
| south_i | input | 4 | South edge input bus |
| east_i | input | 4 | East edge input bus |
| west_i | input | 4 | West edge input bus |
| north_o | output | 4 | North edge output bus |
| south_o | output | 4 | South edge output bus |
| east_o | output | 4 | East edge output bus |
| west_o | output | 4 | West edge output bus |

## Verification
Whenever inputs and configuration are settled, the assertions check that a closed exit gate forces 0, that a 1 on an output always has its exit gate and at least one complete gated route behind it, that any complete route carrying a 1 produces a 1 (the OR merge), and that an empty configuration yields all zeros. The bit positions of gates and crosspoints, the isolation between tracks, the indifference to the low configuration bits and the effect of clearing each of the three bits of a specific route one at a time can only be shown by the bench's directed scenarios and its randomized comparison against an independent model.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int EDGES = 4;
  localparam int EDGE_N = 0;
  localparam int EDGE_S = 1;
  localparam int EDGE_E = 2;
  localparam int EDGE_W = 3;
  localparam int XP_PER_TRACK = EDGES * (EDGES - 1);

  // gate bit of edge e, track b (tracks stored msb-first inside an edge)
  function automatic int en_pos(int en_lo, int w, int e, int b);
    return en_lo + e * w + (w - 1 - b);
  endfunction

  function automatic int src_rank(int s);
    return (s + EDGES - 1) % EDGES;
  endfunction

  function automatic int dst_rank(int s, int d);
    int m;
    m = ((s - d + 2 * EDGES) % EDGES + 2) % EDGES;
    return (m == 3) ? 2 : m;
  endfunction

  function automatic int xp_pos(int xp_hi, int s, int d, int b);
    return xp_hi - (b * XP_PER_TRACK + src_rank(s) * (EDGES - 1) + dst_rank(s, d));
  endfunction

  // compact index of a directed pair inside one track matrix
  function automatic int pair_idx(int s, int d);
    return s * (EDGES - 1) + ((d < s) ? d : d - 1);
  endfunction
endpackage

// File: rtl/sb_edge_gate.sv
module sb_edge_gate #(
  parameter int W = 4
) (
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  assign q_o = d_i & en_i;
endmodule

// File: rtl/sb_track_matrix.sv
module sb_track_matrix
  import sb_pkg::*;
(
  input  logic [EDGES-1:0]        line_i,
  input  logic [XP_PER_TRACK-1:0] xp_i,
  output logic [EDGES-1:0]        line_o
);
  always_comb begin
    for (int d = 0; d < EDGES; d++) begin
      line_o[d] = 1'b0;
      for (int s = 0; s < EDGES; s++) begin
        if (s != d) line_o[d] = line_o[d] | (xp_i[pair_idx(s, d)] & line_i[s]);
      end
    end
  end
endmodule

// File: rtl/sb_gated_switch.sv
module sb_gated_switch
  import sb_pkg::*;
#(
  parameter int W     = 4,
  parameter int CFG_W = 128
) (
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [W-1:0]     north_i,
  input  logic [W-1:0]     south_i,
  input  logic [W-1:0]     east_i,
  input  logic [W-1:0]     west_i,
  output logic [W-1:0]     north_o,
  output logic [W-1:0]     south_o,
  output logic [W-1:0]     east_o,
  output logic [W-1:0]     west_o
);
  localparam int EN_LO = CFG_W - EDGES * W;
  localparam int XP_HI = EN_LO - 1;
  localparam int XP_LO = EN_LO - XP_PER_TRACK * W;

  logic [EDGES-1:0][W-1:0] in_arr, en_arr, gin_arr, raw_arr, out_arr;
  logic [W-1:0][EDGES-1:0] trk_in, trk_out;
  logic [W-1:0][XP_PER_TRACK-1:0] trk_xp;

  assign in_arr[EDGE_N] = north_i;
  assign in_arr[EDGE_S] = south_i;
  assign in_arr[EDGE_E] = east_i;
  assign in_arr[EDGE_W] = west_i;

  for (genvar e = 0; e < EDGES; e++) begin : g_edge
    for (genvar b = 0; b < W; b++) begin : g_en
      assign en_arr[e][b] = cfg_i[en_pos(EN_LO, W, e, b)];
    end
    sb_edge_gate #(.W(W)) u_in_gate (
      .en_i(en_arr[e]), .d_i(in_arr[e]), .q_o(gin_arr[e])
    );
    sb_edge_gate #(.W(W)) u_out_gate (
      .en_i(en_arr[e]), .d_i(raw_arr[e]), .q_o(out_arr[e])
    );
  end

  for (genvar b = 0; b < W; b++) begin : g_trk
    for (genvar s = 0; s < EDGES; s++) begin : g_src
      assign trk_in[b][s]  = gin_arr[s][b];
      assign raw_arr[s][b] = trk_out[b][s];
      for (genvar d = 0; d < EDGES; d++) begin : g_dst
        if (s != d) begin : g_xp
          assign trk_xp[b][pair_idx(s, d)] = cfg_i[xp_pos(XP_HI, s, d, b)];
        end
      end
    end
    sb_track_matrix u_mtx (
      .line_i(trk_in[b]), .xp_i(trk_xp[b]), .line_o(trk_out[b])
    );
  end

  if (XP_LO > 0) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^cfg_i[XP_LO-1:0];
  end

  assign north_o = out_arr[EDGE_N];
  assign south_o = out_arr[EDGE_S];
  assign east_o  = out_arr[EDGE_E];
  assign west_o  = out_arr[EDGE_W];

  // end-to-end checks from ports through gates and matrix
  always_comb begin
    if (!$isunknown({cfg_i, north_i, south_i, east_i, west_i})) begin
      assert_idle_cfg_R10: assert (cfg_i[CFG_W-1:XP_LO] != '0 || out_arr == '0)
        else $error("idle configuration drives a 1");
      for (int d = 0; d < EDGES; d++) begin
        for (int b = 0; b < W; b++) begin
          logic drv;
          drv = 1'b0;
          for (int s = 0; s < EDGES; s++) begin
            if (s != d)
              drv = drv | (cfg_i[xp_pos(XP_HI, s, d, b)] & cfg_i[en_pos(EN_LO, W, s, b)]
                           & in_arr[s][b]);
          end
          assert_exit_gate_R5: assert (cfg_i[en_pos(EN_LO, W, d, b)] || !out_arr[d][b])
            else $error("closed exit gate passes a 1");
          assert_full_route_R3: assert (!out_arr[d][b] || drv)
            else $error("output 1 without a complete route");
          assert_or_merge_R7: assert (!(drv && cfg_i[en_pos(EN_LO, W, d, b)]) || out_arr[d][b])
            else $error("complete route carrying 1 yields 0");
        end
      end
    end
  end
endmodule

// File: tb/sim_sb_gated_switch.sv
module sim_sb_gated_switch;
  localparam int W = 4;
  localparam int CW = 128;

  typedef struct {
    logic [4*W-1:0] exp_out;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [CW-1:0] cfg;
  logic [W-1:0] n_i, s_i, e_i, w_i, n_o, s_o, e_o, w_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  sb_gated_switch #(.W(W), .CFG_W(CW)) u0 (
    .cfg_i(cfg), .north_i(n_i), .south_i(s_i), .east_i(e_i), .west_i(w_i),
    .north_o(n_o), .south_o(s_o), .east_o(e_o), .west_o(w_o)
  );

  // positions as stated in R1 and R2
  function automatic int gbit(int e, int b);
    return 112 + 4 * e + (3 - b);
  endfunction
  function automatic int xbit(int s, int d, int b);
    int m, r;
    m = (((s - d) % 4 + 4) % 4 + 2) % 4;
    r = (m == 3) ? 2 : m;
    return 111 - (12 * b + 3 * ((s + 3) % 4) + r);
  endfunction

  function automatic logic [4*W-1:0] model(logic [CW-1:0] c, logic [4*W-1:0] ins);
    logic [4*W-1:0] o;
    o = '0;
    for (int d = 0; d < 4; d++)
      for (int b = 0; b < W; b++)
        if (c[gbit(d, b)])
          for (int s = 0; s < 4; s++)
            if (s != d && c[xbit(s, d, b)] && c[gbit(s, b)] && ins[s*W+b]) o[d*W+b] = 1'b1;
    return o;
  endfunction

  // inputs packed as {west,east,south,north}
  task automatic drive(logic [CW-1:0] c, logic [4*W-1:0] ins, logic [4*W-1:0] ex, string tag);
    exp_t it;
    @(negedge clk);
    cfg = c;
    {w_i, e_i, s_i, n_i} = ins;
    it.exp_out = ex;
    it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic drive_m(logic [CW-1:0] c, logic [4*W-1:0] ins, string tag);
    drive(c, ins, model(c, ins), tag);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      logic [4*W-1:0] got;
      it = q.pop_front();
      got = {w_o, e_o, s_o, n_o};
      checks++;
      if (got !== it.exp_out) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp_out);
      end
    end
  end

  initial begin
    logic [CW-1:0] c;
    cfg = '0; n_i = '0; s_i = '0; e_i = '0; w_i = '0;
    // R10: empty configuration, all inputs high
    drive('0, '1, '0, "R10 all-zero config");
    // R1 R2 R3: south0 -> west0 via bits 111, 119, 127
    c = '0; c[111] = 1; c[119] = 1; c[127] = 1;
    drive(c, 16'h0010, 16'h1000, "R3 R1 R2 route south0 to west0 high");
    drive(c, 16'h0000, 16'h0000, "R3 route south0 to west0 low");
    // R8: other south tracks toggled
    drive(c, 16'h00E0, 16'h0000, "R8 other tracks isolated");
    drive(c, 16'h00F0, 16'h1000, "R8 routed track with neighbours");
    // R4 R5 R6: clear one bit at a time
    begin logic [CW-1:0] t; t = c; t[119] = 0; drive(t, 16'h0010, 16'h0000, "R4 entry gate cleared"); end
    begin logic [CW-1:0] t; t = c; t[127] = 0; drive(t, 16'h0010, 16'h0000, "R5 exit gate cleared"); end
    begin logic [CW-1:0] t; t = c; t[111] = 0; drive(t, 16'h0010, 16'h0000, "R6 crosspoint cleared"); end
    // R9: noise in low bits
    begin logic [CW-1:0] t; t = c; t[63:0] = {$urandom(), $urandom()};
      drive(t, 16'h0010, 16'h1000, "R9 low bits ignored"); end
    // R7: north0 and south0 both into west0
    c[xbit(0, 3, 0)] = 1; c[gbit(0, 0)] = 1;
    drive(c, 16'h0001, 16'h1000, "R7 or-merge north only");
    drive(c, 16'h0011, 16'h1000, "R7 or-merge both");
    drive(c, 16'h0000, 16'h0000, "R7 or-merge none");
    // R11: south1 to north1 and east1
    c = '0; c[gbit(1, 1)] = 1; c[gbit(0, 1)] = 1; c[gbit(2, 1)] = 1;
    c[xbit(1, 0, 1)] = 1; c[xbit(1, 2, 1)] = 1;
    drive(c, 16'h0020, 16'h0202, "R11 fan-out south1");
    // randomized comparison against the model (R1..R9)
    for (int i = 0; i < 300; i++) begin
      logic [CW-1:0] r;
      r = {$urandom(), $urandom(), $urandom(), $urandom()};
      r[127:112] = r[127:112] | 16'($urandom());
      drive_m(r, 16'($urandom()), "R2 R7 random vector");
    end
    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule